// File: doc/BRIEF.md
# Tangential Octant Coil Code Generator

This block turns a 10-bit pointer angle into signed drive codes for the two quadrature coils of a moving-magnet gauge. It uses a tangent law instead of sine and cosine. The top three angle bits pick one of eight 45-degree octants. In each octant one coil is held at full scale with a fixed sign. The other coil follows the tangent of the offset inside the octant, scaled so that 45 degrees equals full scale. Each coil output is a sign bit plus a magnitude from 0 to 128. A downstream DAC and driver stage turns these into coil voltages.

A client presents an angle together with a one-cycle strobe. On the next clock edge the block registers the new sign and magnitude pair for both coils and raises a one-cycle valid pulse. Between strobes the outputs hold their last values.

The state machine has two states:
- `PH_IDLE`: no new result this cycle.
- `PH_FRESH`: a new result was registered on the last edge.

Its transitions are:
- `strobe`: any state goes to `PH_FRESH` when `angle_vld` is high.
- `quiet`: any state goes to `PH_IDLE` when `angle_vld` is low.

The output valid is high exactly in `PH_FRESH`.

Top module: `tan_coil_gen`

## Requirements
- R1: `angle[9:7]` is the octant number (0 to 7) and `angle[6:0]` is the offset f inside the octant. Step n stands for the angle (n + 0.5) × 360/1024 degrees.
- R2: A magnitude never exceeds 128. The pinned coil always carries exactly 128.
- R3: On every valid result exactly one of the two coil magnitudes equals 128.
- R4: Sign bits use 1 for negative. The octant pattern is:
  - 0: sine varies, positive; cosine full, positive.
  - 1: sine full, positive; cosine varies, positive.
  - 2: sine full, positive; cosine varies, negative.
  - 3: sine varies, positive; cosine full, negative.
  - 4: sine varies, negative; cosine full, negative.
  - 5: sine full, negative; cosine varies, negative.
  - 6: sine full, negative; cosine varies, positive.
  - 7: sine varies, negative; cosine full, positive.
- R5: In even octants the varying magnitude is 128·tan((f+0.5)·45/128°). In odd octants it is 128·tan(45° − (f+0.5)·45/128°). Either value is within ±1 code.
- R6: Across each octant boundary the varying magnitudes are continuous. Offset 127 of an even octant and offset 0 of the following odd octant give 127 on the coil that varies. Offset 127 of an odd octant and offset 0 of the following even octant give 0.
- R7: `code_vld` rises on the clock edge that samples `angle_vld` high and lasts one cycle. Outputs change only on such edges, so an angle presented without the strobe is ignored.
- R8: After reset `code_vld` is 0, both magnitudes are 0 and both sign bits are 0.
- R9: Strobes on consecutive cycles each produce their own result one cycle later, with `code_vld` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| angle_vld | input | 1 | Strobe: angle is valid this cycle |
| angle | input | 10 | Octant in bits 9:7, offset in bits 6:0 |
| code_vld | output | 1 | One-cycle pulse with a new result |
| sin_neg | output | 1 | Sine coil sign, 1 = negative |
| sin_mag | output | 8 | Sine coil magnitude, 0 to 128 |
| cos_neg | output | 1 | Cosine coil sign, 1 = negative |
| cos_mag | output | 8 | Cosine coil magnitude, 0 to 128 |

## Verification
The hardest situations to reach are the octant seams, where the mirrored index must hand over between the two coils with no jump. The other is the case where the angle changes while the strobe is low. The stimulus sweeps all 1024 codes in order, so every seam is crossed. It then drives the exact codes on each side of all eight seams. It also scrambles the angle bus during quiet cycles and confirms the held outputs do not move. Back-to-back strobes alternate between seam codes so that each result must track its own angle.

// File: rtl/tan_coil_pkg.sv
package tan_coil_pkg;

    typedef enum logic [2:0] {
        OCT_0, OCT_1, OCT_2, OCT_3, OCT_4, OCT_5, OCT_6, OCT_7
    } octant_e;

    typedef struct packed {
        logic sin_vary;
        logic sin_neg;
        logic cos_neg;
        logic mirror;
    } oct_ctl_t;

    typedef enum logic {
        PH_IDLE,
        PH_FRESH
    } phase_e;

endpackage

// File: rtl/tan_oct_decode.sv
module tan_oct_decode
    import tan_coil_pkg::*;
(
    input  logic [2:0] octant,
    output oct_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        unique case (octant_e'(octant))
            OCT_0: ctl = '{sin_vary: 1'b1, sin_neg: 1'b0, cos_neg: 1'b0, mirror: 1'b0};
            OCT_1: ctl = '{sin_vary: 1'b0, sin_neg: 1'b0, cos_neg: 1'b0, mirror: 1'b1};
            OCT_2: ctl = '{sin_vary: 1'b0, sin_neg: 1'b0, cos_neg: 1'b1, mirror: 1'b0};
            OCT_3: ctl = '{sin_vary: 1'b1, sin_neg: 1'b0, cos_neg: 1'b1, mirror: 1'b1};
            OCT_4: ctl = '{sin_vary: 1'b1, sin_neg: 1'b1, cos_neg: 1'b1, mirror: 1'b0};
            OCT_5: ctl = '{sin_vary: 1'b0, sin_neg: 1'b1, cos_neg: 1'b1, mirror: 1'b1};
            OCT_6: ctl = '{sin_vary: 1'b0, sin_neg: 1'b1, cos_neg: 1'b0, mirror: 1'b0};
            OCT_7: ctl = '{sin_vary: 1'b1, sin_neg: 1'b1, cos_neg: 1'b0, mirror: 1'b1};
            default: ctl = '0;
        endcase
    end

    // R4: odd octants always mirror, even never do
    always_comb begin
        if (!$isunknown(octant)) begin
            p_mirror_odd_r4: assert (ctl.mirror == octant[0]);
        end
    end
endmodule

// File: rtl/tan_rom.sv
module tan_rom #(
    parameter int OFS_W = 7
) (
    input  logic [OFS_W-1:0] idx,
    output logic [OFS_W:0]   mag
);
    localparam int N     = 1 << OFS_W;
    localparam int MAG_W = OFS_W + 1;

    function automatic logic [N*MAG_W-1:0] build_table();
        logic [N*MAG_W-1:0] tbl;
        real x, s, c, ts, tc, r;
        tbl = '0;
        for (int k = 0; k < N; k++) begin
            x  = (real'(k) + 0.5) * 3.14159265358979 / (4.0 * real'(N));
            s  = 0.0;
            c  = 0.0;
            ts = x;
            tc = 1.0;
            for (int j = 1; j <= 9; j++) begin
                s  = s + ts;
                c  = c + tc;
                ts = -ts * x * x / (real'(2 * j) * real'(2 * j + 1));
                tc = -tc * x * x / (real'(2 * j - 1) * real'(2 * j));
            end
            r = real'(N) * s / c + 0.5;
            tbl[k*MAG_W +: MAG_W] = MAG_W'($rtoi(r));
        end
        return tbl;
    endfunction

    localparam logic [N*MAG_W-1:0] TAN_TBL = build_table();

    assign mag = TAN_TBL[idx*MAG_W +: MAG_W];

    // R2: the varying coil stays strictly below full scale
    always_comb begin
        if (!$isunknown(idx)) begin
            p_tan_below_full_r2: assert (mag < MAG_W'(N));
        end
    end
endmodule

// File: rtl/tan_coil_gen.sv
module tan_coil_gen
    import tan_coil_pkg::*;
#(
    parameter int ANG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             angle_vld,
    input  logic [ANG_W-1:0] angle,
    output logic             code_vld,
    output logic             sin_neg,
    output logic [ANG_W-3:0] sin_mag,
    output logic             cos_neg,
    output logic [ANG_W-3:0] cos_mag
);
    localparam int OFS_W = ANG_W - 3;
    localparam int MAG_W = OFS_W + 1;
    localparam logic [MAG_W-1:0] FULL = MAG_W'(1 << OFS_W);

    oct_ctl_t         ctl;
    logic [OFS_W-1:0] ofs, rom_idx;
    logic [MAG_W-1:0] var_mag, sin_d, cos_d;
    phase_e           phase, phase_nx;

    tan_oct_decode u_dec (
        .octant (angle[ANG_W-1 -: 3]),
        .ctl    (ctl)
    );

    assign ofs     = angle[OFS_W-1:0];
    assign rom_idx = ctl.mirror ? ~ofs : ofs;

    tan_rom #(.OFS_W(OFS_W)) u_rom (
        .idx (rom_idx),
        .mag (var_mag)
    );

    assign sin_d = ctl.sin_vary ? var_mag : FULL;
    assign cos_d = ctl.sin_vary ? FULL : var_mag;

    always_comb begin
        phase_nx = PH_IDLE;
        unique case (phase)
            PH_IDLE:  phase_nx = angle_vld ? PH_FRESH : PH_IDLE;
            PH_FRESH: phase_nx = angle_vld ? PH_FRESH : PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sin_neg <= 1'b0;
            cos_neg <= 1'b0;
            sin_mag <= '0;
            cos_mag <= '0;
        end else if (angle_vld) begin
            sin_neg <= ctl.sin_neg;
            cos_neg <= ctl.cos_neg;
            sin_mag <= sin_d;
            cos_mag <= cos_d;
        end
    end

    assign code_vld = (phase == PH_FRESH);

    p_one_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> $countones({sin_mag == FULL, cos_mag == FULL}) == 1);

    p_mag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_mag <= FULL) && (cos_mag <= FULL));

    p_vld_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        angle_vld |=> code_vld);

    p_vld_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !angle_vld |=> !code_vld);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !angle_vld |=> ($stable(sin_mag) && $stable(cos_mag)
                        && $stable(sin_neg) && $stable(cos_neg)));
endmodule

// File: tb/sim_tan_coil_gen.sv
module sim_tan_coil_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       angle_vld = 1'b0;
    logic [9:0] angle = '0;
    logic       code_vld, sin_neg, cos_neg;
    logic [7:0] sin_mag, cos_mag;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tan_coil_gen u0 (
        .clk(clk), .rst_n(rst_n), .angle_vld(angle_vld), .angle(angle),
        .code_vld(code_vld), .sin_neg(sin_neg), .sin_mag(sin_mag),
        .cos_neg(cos_neg), .cos_mag(cos_mag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s angle=%0d actual=%0d expected=%0d", req, angle, act, exp);
        end
    endtask

    // reference varying magnitude from real arithmetic
    function automatic int ref_var(input int code);
        real th, a;
        int  o;
        o  = code / 128;
        th = (real'(code) + 0.5) * 360.0 / 1024.0;
        a  = th - 45.0 * real'(o);
        if (o % 2 == 1) a = 45.0 - a;
        return $rtoi(128.0 * $tan(a * 3.14159265358979 / 180.0) + 0.5);
    endfunction

    function automatic bit ref_sin_vary(input int o);
        return (o == 0 || o == 3 || o == 4 || o == 7);
    endfunction

    function automatic bit ref_sin_neg(input int o);
        return (o >= 4);
    endfunction

    function automatic bit ref_cos_neg(input int o);
        return (o >= 2 && o <= 5);
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic strobe(input int code);
        @(negedge clk);
        angle     = 10'(code);
        angle_vld = 1'b1;
        @(negedge clk);
        angle_vld = 1'b0;
    endtask

    task automatic check_result(input int code);
        int o, v;
        o = code / 128;
        v = ref_var(code);
        chk(code_vld == 1'b1, "R7", code_vld, 1);
        chk(sin_neg == ref_sin_neg(o), "R4", sin_neg, ref_sin_neg(o));
        chk(cos_neg == ref_cos_neg(o), "R4", cos_neg, ref_cos_neg(o));
        chk((sin_mag == 128) + (cos_mag == 128) == 1, "R3", sin_mag, cos_mag);
        if (ref_sin_vary(o)) begin
            chk(cos_mag == 128, "R2", cos_mag, 128);
            chk(near(sin_mag, v), "R5", sin_mag, v);
        end else begin
            chk(sin_mag == 128, "R2", sin_mag, 128);
            chk(near(cos_mag, v), "R5", cos_mag, v);
        end
    endtask

    task automatic t_reset();
        chk(code_vld == 0, "R8", code_vld, 0);
        chk(sin_mag == 0, "R8", sin_mag, 0);
        chk(cos_mag == 0, "R8", cos_mag, 0);
        chk(sin_neg == 0 && cos_neg == 0, "R8", {sin_neg, cos_neg}, 0);
    endtask

    task automatic t_sweep();   // R1 R4 R5 over all codes
        for (int c = 0; c < 1024; c++) begin
            strobe(c);
            check_result(c);
        end
    endtask

    task automatic t_seams();   // R6
        for (int o = 0; o < 8; o++) begin
            int lo, hi, exp;
            lo  = o * 128 + 127;
            hi  = ((o + 1) % 8) * 128;
            exp = (o % 2 == 0) ? 127 : 0;
            strobe(lo);
            chk(near(ref_sin_vary(o) ? sin_mag : cos_mag, exp), "R6",
                ref_sin_vary(o) ? sin_mag : cos_mag, exp);
            strobe(hi);
            chk(near(ref_sin_vary((o + 1) % 8) ? sin_mag : cos_mag, exp), "R6",
                ref_sin_vary((o + 1) % 8) ? sin_mag : cos_mag, exp);
        end
    endtask

    task automatic t_ignore();  // R7
        logic [7:0] s0, c0;
        logic       sn0, cn0;
        strobe(200);
        s0 = sin_mag; c0 = cos_mag; sn0 = sin_neg; cn0 = cos_neg;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            angle = 10'(700 + 37 * k);
            chk(code_vld == 0, "R7", code_vld, 0);
            chk(sin_mag == s0 && cos_mag == c0, "R7", {sin_mag, cos_mag}, {s0, c0});
            chk(sin_neg == sn0 && cos_neg == cn0, "R7", {sin_neg, cos_neg}, {sn0, cn0});
        end
    endtask

    task automatic t_back2back();   // R9
        int codes [4] = '{127, 128, 639, 640};
        @(negedge clk);
        angle = 10'(codes[0]);
        angle_vld = 1'b1;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            check_result(codes[i-1]);
            chk(code_vld == 1, "R9", code_vld, 1);
            angle = 10'(codes[i]);
        end
        @(negedge clk);
        angle_vld = 1'b0;
        check_result(codes[3]);
        @(negedge clk);
        chk(code_vld == 0, "R9", code_vld, 1'b0);
    endtask

    initial begin
        #200_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_seams();
        t_ignore();
        t_back2back();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule